// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the bus-facing register file of an interrupt controller. A 32-bit word bus reads and writes a 4 KB register window, and the block turns those accesses into bit-level changes on the per-vector enable, pending and priority state that it keeps. It also holds the system-exception pending flags, the system-handler priorities, the priority-group field and the vector-table base. The arbiter that chooses the next exception lives elsewhere. It takes the state outputs of this block and returns the active vector, the pending vector, the return-to-base flag and the per-line active bits. This block folds those inputs into its read data.

External line n is exception 16+n. Set and clear arrays share storage, and both addresses of a pair read back the same bits. Writes to the reset and priority-group control are accepted only with a key. Software can also pend a line through a trigger register, subject to a privilege check. Accesses are whole words, and `addr_i` carries byte-address bits 11:2.

Top module: `intc_reg_front`

## Requirements
- R1: A write to the enable-set words (byte offsets 0x100-0x13F) sets the enable of line 8·(offset−0x100)+b for every 1 in bit b. A write to the enable-clear words (0x180-0x1BF) clears the same bits. Zero bits leave the state unchanged. A read of either word returns the enable bits of its 32 lines.
- R2: The pending-set words (0x200-0x23F) and pending-clear words (0x280-0x2BF) follow the R1 rule for the pending bits.
- R3: The active words at 0x300-0x33F read `irq_active_i` using the same line mapping, and writes to them change nothing.
- R4: Priority bytes at 0x400-0x5EF are packed four per word. Byte lane l of the word at offset a is the priority of line (a−0x400)+l, and that priority appears on `irq_prio_o[8n+7:8n]`.
- R5: System-handler priority bytes at 0xD18-0xD23 hold the priority of exception (a−0xD14)+l for byte lane l. Exception e appears on `sys_prio_o[8(e−4)+7:8(e−4)]`.
- R6: A read of 0xD04 returns `active_vec_i` in bits 8:0, `ret_base_i` in bit 11, `pend_vec_i` in bits 19:12, the OR of all line pending bits in bit 22, and the SysTick, PendSV and NMI pending flags in bits 26, 28 and 31. All other bits read as zero.
- R7: On a write to 0xD04, bit 31 pends NMI. Bit 28 pends PendSV; otherwise bit 27 clears it. Bit 26 pends SysTick; otherwise bit 25 clears it. No write clears the NMI flag.
- R8: A write to 0xD0C is accepted only when bits 31:16 equal 0x05FA. An accepted write loads the priority group from bits 10:8, and if bit 2 is set it raises `sys_reset_req_o` for the one following cycle. A read of 0xD0C returns 0xFA05 in bits 31:16 and the group in bits 10:8.
- R9: A write to 0xF00 pends line n=value[8:0] only when n < NUM_IRQ and either `priv_i` or `user_pend_en_i` is high.
- R10: A write to 0xD08 keeps bits 31:7 and clears bits 6:0. A read of 0xD08 returns the stored value.
- R11: Bits of lines at or above NUM_IRQ read as zero, and writes to them are ignored.
- R12: Any offset not listed above reads as zero and ignores writes. An access to such an offset raises `err_o` in the following cycle for one cycle.
- R13: After reset, all enable, pending and priority bits, the system flags, the group, the vector base and both pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Word write strobe |
| rd_en_i | input | 1 | Word read strobe |
| addr_i | input | 10 | Byte address bits 11:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| priv_i | input | 1 | Core is privileged |
| user_pend_en_i | input | 1 | Unprivileged trigger allowed |
| active_vec_i | input | 9 | Currently active exception |
| pend_vec_i | input | 8 | Highest pending exception |
| ret_base_i | input | 1 | Only one handler active |
| irq_active_i | input | NUM_IRQ | Per-line active bits |
| irq_enable_o | output | NUM_IRQ | Per-line enable bits |
| irq_pend_o | output | NUM_IRQ | Per-line pending bits |
| irq_prio_o | output | 8·NUM_IRQ | Per-line priorities |
| sys_prio_o | output | 96 | Priorities of exceptions 4-15 |
| nmi_pend_o | output | 1 | NMI pending |
| pendsv_pend_o | output | 1 | PendSV pending |
| systick_pend_o | output | 1 | SysTick pending |
| prigroup_o | output | 3 | Priority group |
| vtor_o | output | 32 | Vector table base |
| sys_reset_req_o | output | 1 | One-cycle reset request |
| err_o | output | 1 | One-cycle unmapped-access flag |

## Verification
Enable and pending words are written with sparse patterns, full-ones patterns and single-bit patterns. This separates set from clear, shows that zero bits are neutral, and shows that both addresses of a pair read back the same bits. With NUM_IRQ=40, the second word is partly populated and the third word is fully outside the configured lines, which exposes R11 truncation. The control-state writes send set and clear bits together and separately, and this settles which one takes precedence. The keyed register is written with a wrong key and then the right key. The trigger register is exercised under all privilege cases and with an out-of-range line number.

// File: rtl/intc_reg_front.sv
`timescale 1ns/1ps
module intc_reg_front #(
  parameter int NUM_IRQ = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [11:2]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic                 priv_i,
  input  logic                 user_pend_en_i,
  input  logic [8:0]           active_vec_i,
  input  logic [7:0]           pend_vec_i,
  input  logic                 ret_base_i,
  input  logic [NUM_IRQ-1:0]   irq_active_i,
  output logic [NUM_IRQ-1:0]   irq_enable_o,
  output logic [NUM_IRQ-1:0]   irq_pend_o,
  output logic [8*NUM_IRQ-1:0] irq_prio_o,
  output logic [95:0]          sys_prio_o,
  output logic                 nmi_pend_o,
  output logic                 pendsv_pend_o,
  output logic                 systick_pend_o,
  output logic [2:0]           prigroup_o,
  output logic [31:0]          vtor_o,
  output logic                 sys_reset_req_o,
  output logic                 err_o
);
  localparam int SysN  = 12;
  localparam int LineW = 512;
  localparam int PrioW = 4096;

  logic [3:0] aw;
  logic [6:0] pw;
  logic [1:0] sw;
  logic in_sen, in_cen, in_spn, in_cpn, in_act, in_pri, in_spr;
  logic in_ics, in_vtor, in_air, in_stir, mapped, key_ok, stir_go;
  logic [8:0] stir_n;

  assign aw      = addr_i[5:2];
  assign pw      = addr_i[8:2];
  assign sw      = addr_i[3:2] - 2'd2;
  assign in_sen  = addr_i[11:6] == 6'h04;
  assign in_cen  = addr_i[11:6] == 6'h06;
  assign in_spn  = addr_i[11:6] == 6'h08;
  assign in_cpn  = addr_i[11:6] == 6'h0A;
  assign in_act  = addr_i[11:6] == 6'h0C;
  assign in_pri  = addr_i[11:9] == 3'b010 && addr_i[8:2] < 7'd124;
  assign in_spr  = addr_i >= 10'h346 && addr_i <= 10'h348;
  assign in_ics  = addr_i == 10'h341;
  assign in_vtor = addr_i == 10'h342;
  assign in_air  = addr_i == 10'h343;
  assign in_stir = addr_i == 10'h3C0;
  assign mapped  = in_sen | in_cen | in_spn | in_cpn | in_act | in_pri | in_spr |
                   in_ics | in_vtor | in_air | in_stir;
  assign key_ok  = wdata_i[31:16] == 16'h05FA;
  assign stir_n  = wdata_i[8:0];
  assign stir_go = wr_en_i && in_stir && (priv_i || user_pend_en_i) &&
                   32'(stir_n) < NUM_IRQ;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam int Wd = i / 32;
    localparam int Bt = i % 32;
    localparam int Pw = i / 4;
    localparam int Ln = i % 4;
    logic en_r, pd_r, hit;
    logic [7:0] pr_r;
    assign hit = wr_en_i && wdata_i[Bt] && aw == Wd[3:0];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_r <= 1'b0;
        pd_r <= 1'b0;
        pr_r <= 8'h00;
      end else begin
        if (hit && in_sen) en_r <= 1'b1;
        if (hit && in_cen) en_r <= 1'b0;
        if ((hit && in_spn) || (stir_go && stir_n == i[8:0])) pd_r <= 1'b1;
        else if (hit && in_cpn) pd_r <= 1'b0;
        if (wr_en_i && in_pri && pw == Pw[6:0]) pr_r <= wdata_i[8*Ln +: 8];
      end
    end
    assign irq_enable_o[i]     = en_r;
    assign irq_pend_o[i]       = pd_r;
    assign irq_prio_o[8*i +: 8] = pr_r;
  end

  for (genvar k = 0; k < SysN; k++) begin : g_sys
    localparam int Sw = k / 4;
    localparam int Ln = k % 4;
    logic [7:0] sp_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sp_r <= 8'h00;
      else if (wr_en_i && in_spr && sw == Sw[1:0]) sp_r <= wdata_i[8*Ln +: 8];
    end
    assign sys_prio_o[8*k +: 8] = sp_r;
  end

  logic [24:0] vtor_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_pend_o      <= 1'b0;
      pendsv_pend_o   <= 1'b0;
      systick_pend_o  <= 1'b0;
      prigroup_o      <= 3'd0;
      vtor_q          <= '0;
      sys_reset_req_o <= 1'b0;
      err_o           <= 1'b0;
    end else begin
      if (wr_en_i && in_ics) begin
        if (wdata_i[31]) nmi_pend_o <= 1'b1;
        if (wdata_i[28]) pendsv_pend_o <= 1'b1;
        else if (wdata_i[27]) pendsv_pend_o <= 1'b0;
        if (wdata_i[26]) systick_pend_o <= 1'b1;
        else if (wdata_i[25]) systick_pend_o <= 1'b0;
      end
      if (wr_en_i && in_air && key_ok) prigroup_o <= wdata_i[10:8];
      if (wr_en_i && in_vtor) vtor_q <= wdata_i[31:7];
      sys_reset_req_o <= wr_en_i && in_air && key_ok && wdata_i[2];
      err_o           <= (wr_en_i || rd_en_i) && !mapped;
    end
  end
  assign vtor_o = {vtor_q, 7'd0};

  logic [LineW-1:0] en_pad, pd_pad, ac_pad;
  logic [PrioW-1:0] pr_pad;
  logic [127:0]     sp_pad;
  assign en_pad = {{(LineW-NUM_IRQ){1'b0}}, irq_enable_o};
  assign pd_pad = {{(LineW-NUM_IRQ){1'b0}}, irq_pend_o};
  assign ac_pad = {{(LineW-NUM_IRQ){1'b0}}, irq_active_i};
  assign pr_pad = {{(PrioW-8*NUM_IRQ){1'b0}}, irq_prio_o};
  assign sp_pad = {32'd0, sys_prio_o};

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (in_sen || in_cen)      rdata_o = en_pad[{aw, 5'd0} +: 32];
      else if (in_spn || in_cpn) rdata_o = pd_pad[{aw, 5'd0} +: 32];
      else if (in_act)           rdata_o = ac_pad[{aw, 5'd0} +: 32];
      else if (in_pri)           rdata_o = pr_pad[{pw, 5'd0} +: 32];
      else if (in_spr)           rdata_o = sp_pad[{sw, 5'd0} +: 32];
      else if (in_ics)
        rdata_o = {nmi_pend_o, 2'b0, pendsv_pend_o, 1'b0, systick_pend_o, 3'b0,
                   |irq_pend_o, 2'b0, pend_vec_i, ret_base_i, 2'b0, active_vec_i};
      else if (in_vtor)          rdata_o = vtor_o;
      else if (in_air)           rdata_o = {16'hFA05, 5'd0, prigroup_o, 8'd0};
    end
  end

  // R12
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_en_i || wr_en_i));
  // R8
  rst_req_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |-> $past(wr_en_i && wdata_i[31:16] == 16'h05FA && wdata_i[2]));
  // R8
  group_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prigroup_o) |-> $past(wr_en_i && wdata_i[31:16] == 16'h05FA));
  // R7
  nmi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(nmi_pend_o));
  // R1
  enable_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_enable_o) |-> $past(wr_en_i));
  // R2
  pend_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_pend_o) |-> $past(wr_en_i));
endmodule

// File: tb/intc_reg_front_tb.sv
`timescale 1ns/1ps
module intc_reg_front_tb_top;
  localparam int N = 40;
  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [11:0] a = 0;
  logic [31:0] wd = 0, rdata;
  logic priv = 0, upen = 0, rtb = 0;
  logic [8:0] avec = 0;
  logic [7:0] pvec = 0;
  logic [N-1:0] iact = 0, en_o, pd_o;
  logic [8*N-1:0] pr_o;
  logic [95:0] sp_o;
  logic nmi_o, psv_o, stk_o, rr_o, err_o;
  logic [2:0] grp_o;
  logic [31:0] vtor_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_reg_front #(.NUM_IRQ(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(a[11:2]),
    .wdata_i(wd), .rdata_o(rdata), .priv_i(priv), .user_pend_en_i(upen),
    .active_vec_i(avec), .pend_vec_i(pvec), .ret_base_i(rtb), .irq_active_i(iact),
    .irq_enable_o(en_o), .irq_pend_o(pd_o), .irq_prio_o(pr_o), .sys_prio_o(sp_o),
    .nmi_pend_o(nmi_o), .pendsv_pend_o(psv_o), .systick_pend_o(stk_o),
    .prigroup_o(grp_o), .vtor_o(vtor_o), .sys_reset_req_o(rr_o), .err_o(err_o));

  bit men[N], mpd[N];
  int mpr[N], msp[12];
  bit mnmi, mpsv, mstk, mrr, merr;
  int mgrp;
  logic [31:0] mvtor;

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_mapped(int x);
    return (x >= 'h100 && x < 'h140) || (x >= 'h180 && x < 'h1C0) ||
           (x >= 'h200 && x < 'h240) || (x >= 'h280 && x < 'h2C0) ||
           (x >= 'h300 && x < 'h340) || (x >= 'h400 && x < 'h5F0) ||
           (x >= 'hD18 && x < 'hD24) || x == 'hD04 || x == 'hD08 ||
           x == 'hD0C || x == 'hF00;
  endfunction

  function automatic logic [31:0] mread(int x);
    logic [31:0] r = 0;
    int base;
    if ((x >= 'h100 && x < 'h140) || (x >= 'h180 && x < 'h1C0)) begin
      base = (x < 'h180) ? x - 'h100 : x - 'h180;
      for (int b = 0; b < 32; b++) if (base*8+b < N) r[b] = men[base*8+b];
    end else if ((x >= 'h200 && x < 'h240) || (x >= 'h280 && x < 'h2C0)) begin
      base = (x < 'h280) ? x - 'h200 : x - 'h280;
      for (int b = 0; b < 32; b++) if (base*8+b < N) r[b] = mpd[base*8+b];
    end else if (x >= 'h300 && x < 'h340) begin
      for (int b = 0; b < 32; b++) if ((x-'h300)*8+b < N) r[b] = iact[(x-'h300)*8+b];
    end else if (x >= 'h400 && x < 'h5F0) begin
      for (int l = 0; l < 4; l++) if (x-'h400+l < N) r[8*l +: 8] = 8'(mpr[x-'h400+l]);
    end else if (x >= 'hD18 && x < 'hD24) begin
      for (int l = 0; l < 4; l++) r[8*l +: 8] = 8'(msp[x-'hD14+l-4]);
    end else if (x == 'hD04) begin
      r[8:0] = avec; r[11] = rtb; r[19:12] = pvec;
      for (int v = 0; v < N; v++) if (mpd[v]) r[22] = 1;
      r[26] = mstk; r[28] = mpsv; r[31] = mnmi;
    end else if (x == 'hD08) r = mvtor;
    else if (x == 'hD0C) r = 32'hFA05_0000 | (32'(mgrp) << 8);
    return r;
  endfunction

  always @(posedge clk) begin
    int x;
    x = int'(a) & 'hFFC;
    if (!rst_n) begin
      foreach (men[v]) begin men[v] = 0; mpd[v] = 0; mpr[v] = 0; end
      foreach (msp[k]) msp[k] = 0;
      mnmi = 0; mpsv = 0; mstk = 0; mrr = 0; merr = 0; mgrp = 0; mvtor = 0;
    end else begin
      mrr = 0;
      merr = (wr || rd) && !is_mapped(x);
      if (wr) begin
        for (int b = 0; b < 32; b++) if (wd[b]) begin
          if (x >= 'h100 && x < 'h140 && (x-'h100)*8+b < N) men[(x-'h100)*8+b] = 1;
          if (x >= 'h180 && x < 'h1C0 && (x-'h180)*8+b < N) men[(x-'h180)*8+b] = 0;
          if (x >= 'h200 && x < 'h240 && (x-'h200)*8+b < N) mpd[(x-'h200)*8+b] = 1;
          if (x >= 'h280 && x < 'h2C0 && (x-'h280)*8+b < N) mpd[(x-'h280)*8+b] = 0;
        end
        if (x >= 'h400 && x < 'h5F0)
          for (int l = 0; l < 4; l++) if (x-'h400+l < N) mpr[x-'h400+l] = int'(wd[8*l +: 8]);
        if (x >= 'hD18 && x < 'hD24)
          for (int l = 0; l < 4; l++) msp[x-'hD14+l-4] = int'(wd[8*l +: 8]);
        if (x == 'hD04) begin
          if (wd[31]) mnmi = 1;
          if (wd[28]) mpsv = 1; else if (wd[27]) mpsv = 0;
          if (wd[26]) mstk = 1; else if (wd[25]) mstk = 0;
        end
        if (x == 'hD08) mvtor = wd & 32'hFFFF_FF80;
        if (x == 'hD0C && wd[31:16] == 16'h05FA) begin
          mgrp = int'(wd[10:8]);
          mrr = wd[2];
        end
        if (x == 'hF00 && (priv || upen) && int'(wd[8:0]) < N) mpd[wd[8:0]] = 1;
      end
    end
  end

  always @(negedge clk) begin
    logic [N-1:0] ee, ep;
    logic [8*N-1:0] eprio;
    logic [95:0] esp;
    string tg;
    for (int v = 0; v < N; v++) begin
      ee[v] = men[v]; ep[v] = mpd[v]; eprio[8*v +: 8] = 8'(mpr[v]);
    end
    for (int k = 0; k < 12; k++) esp[8*k +: 8] = 8'(msp[k]);
    tg = rst_n ? "" : "R13 ";
    check(en_o == ee, {tg, "R1 enable"}, 512'(en_o), 512'(ee));
    check(pd_o == ep, {tg, "R2 pending"}, 512'(pd_o), 512'(ep));
    check(pr_o == eprio, {tg, "R4 prio"}, 512'(pr_o), 512'(eprio));
    check(sp_o == esp, {tg, "R5 sysprio"}, 512'(sp_o), 512'(esp));
    check({nmi_o, psv_o, stk_o} == {mnmi, mpsv, mstk}, {tg, "R7 sysflags"},
          512'({nmi_o, psv_o, stk_o}), 512'({mnmi, mpsv, mstk}));
    check(grp_o == 3'(mgrp) && rr_o == mrr, {tg, "R8 group/reset"},
          512'({grp_o, rr_o}), 512'({3'(mgrp), mrr}));
    check(vtor_o == mvtor, {tg, "R10 vtor"}, 512'(vtor_o), 512'(mvtor));
    check(err_o == merr, {tg, "R12 err"}, 512'(err_o), 512'(merr));
  end

  task automatic wr_w(int x, logic [31:0] d);
    @(negedge clk); wr = 1; rd = 0; a = 12'(x); wd = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_w(int x, string req);
    @(negedge clk); rd = 1; wr = 0; a = 12'(x);
    #2 check(rdata == mread(x), req, 512'(rdata), 512'(mread(x)));
    @(negedge clk); rd = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R11
    wr_w('h100, 32'hA5A5_0003); rd_w('h100, "R1 set alias"); rd_w('h180, "R1 clr alias");
    wr_w('h180, 32'h0000_0001); rd_w('h100, "R1 clear bit");
    wr_w('h104, 32'hFFFF_FFFF); rd_w('h184, "R11 partial word");
    wr_w('h108, 32'hFFFF_FFFF); rd_w('h108, "R11 beyond lines");
    wr_w('h184, 32'h0000_0010); rd_w('h104, "R1 clear high word");
    // R2
    wr_w('h200, 32'h8000_0101); rd_w('h280, "R2 set");
    wr_w('h280, 32'h0000_0100); rd_w('h200, "R2 clear");
    wr_w('h204, 32'h0000_0F00); rd_w('h204, "R2 high word");
    // R3
    iact = 40'hC3_1234_5678;
    rd_w('h300, "R3 active w0"); rd_w('h304, "R3 active w1");
    wr_w('h300, 32'hFFFF_FFFF); rd_w('h300, "R3 write ignored");
    // R4 / R11
    wr_w('h400, 32'h1122_3344); wr_w('h424, 32'hDEAD_BEEF); wr_w('h428, 32'hFFFF_FFFF);
    rd_w('h400, "R4 prio w0"); rd_w('h424, "R4 prio last"); rd_w('h428, "R11 prio beyond");
    // R5
    wr_w('hD18, 32'hA0B0_C0D0); wr_w('hD20, 32'h0102_0304); wr_w('hD1C, 32'h5566_7788);
    rd_w('hD18, "R5 w0"); rd_w('hD1C, "R5 w1"); rd_w('hD20, "R5 w2");
    // R7 / R6
    wr_w('hD04, 32'h9400_0000); rd_w('hD04, "R7 set all");
    wr_w('hD04, 32'h0A00_0000); rd_w('hD04, "R7 clear");
    wr_w('hD04, 32'h1E00_0000); rd_w('hD04, "R7 set wins");
    avec = 9'h1AB; pvec = 8'h5C; rtb = 1;
    rd_w('hD04, "R6 layout");
    wr_w('h280, 32'hFFFF_FFFF); wr_w('h284, 32'hFFFF_FFFF);
    rd_w('hD04, "R6 no ext pend");
    // R8
    wr_w('hD0C, 32'h05FB_0704); rd_w('hD0C, "R8 bad key");
    wr_w('hD0C, 32'h05FA_0504); rd_w('hD0C, "R8 good key");
    wr_w('hD0C, 32'h05FA_0300); rd_w('hD0C, "R8 no reset bit");
    // R9
    wr_w('hF00, 32'd3); rd_w('h200, "R9 unpriv blocked");
    priv = 1; wr_w('hF00, 32'd3); rd_w('h200, "R9 priv");
    wr_w('hF00, 32'd45); rd_w('h204, "R9 out of range");
    priv = 0; upen = 1; wr_w('hF00, 32'd39); rd_w('h204, "R9 user enabled");
    // R10
    wr_w('hD08, 32'hFFFF_FFFF); rd_w('hD08, "R10 vtor");
    wr_w('hD08, 32'h1234_5678); rd_w('hD08, "R10 vtor2");
    // R12
    rd_w('h800, "R12 unmapped read"); wr_w('hD10, 32'hFFFF_FFFF);
    rd_w('hD10, "R12 unmapped write"); rd_w('hF04, "R12 stir neighbour");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule